// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Frequency Selector

This block sits in the control section of a multi-output clock generator. During power-up a few dual-use pins carry configuration straps instead of clocks: a three-bit frequency select, a table select and a test-mode request. When the active-low power-good input asserts, the block samples these pins once, holds the values, and then signals that the pins may switch over to driving clock outputs.

From the held straps, or from a control register when software asks for it, the block builds a five-bit processor-domain selection code and a spread enable. It also derives an overclock step and a spread enable for the peripheral (PCI Express and graphics) domain. A register code that names no valid frequency is replaced by the 100 MHz processor setting. A test-mode request seen at capture time stays latched until the next power-on reset. While the power-down input is high, every register in the block holds its value.

Top module: `strap_freq_ctrl`

## Requirements
- R1: While rst_n is low: strap_drive, cap_pulse, test_mode, cpu_spread, periph_step and periph_spread are 0, and cpu_code is 5'b00101.
- R2: With pwr_dn low, cap_pulse is high for exactly one cycle, SYNC_STAGES+1 rising edges after pg_n is first seen low. strap_drive rises in the same cycle and stays high.
- R3: Straps are captured once per reset. Later pg_n toggles and strap changes raise no new cap_pulse and change neither cpu_code nor test_mode.
- R4: ctrl_reg[7] selects the source. With 0, cpu_code[4] and cpu_code[2:0] come from the captured strap_tbl and strap_fs. With 1, they come from ctrl_reg[4] and ctrl_reg[2:0].
- R5: cpu_code[3] always follows ctrl_reg[3]. cpu_spread is 1 only when ctrl_reg[6] and ctrl_reg[3] are both 1.
- R6: A code with table bit 0 and frequency field 3'b111 is reserved and comes out as frequency field 3'b101 with table bit 0. Bit 3 is kept. This holds for both sources.
- R7: In strap mode before capture, cpu_code[4] is 0 and cpu_code[2:0] is 3'b101.
- R8: periph_code follows periph_reg[3:0]. periph_step equals periph_reg[3:2], where step 0, 1, 2 and 3 mean 100, 101, 102 and 104 MHz. periph_spread follows periph_reg[4].
- R9: test_mode takes the value of strap_test at capture and holds it until rst_n goes low.
- R10: While pwr_dn is high, all outputs hold, capture does not happen, and the pending work resumes after pwr_dn falls.
- R11: The selection outputs are registered. They change on the first rising edge after a register input changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_dn | input | 1 | Power-down; high freezes every register |
| pg_n | input | 1 | Active-low power-good, asynchronous |
| strap_fs | input | FS_W | Frequency select strap pins |
| strap_tbl | input | 1 | Table select strap pin |
| strap_test | input | 1 | Test-mode request strap pin |
| ctrl_reg | input | 8 | Processor selection control register |
| periph_reg | input | 5 | Peripheral spread and overclock register |
| strap_drive | output | 1 | Shared pins may now drive clocks |
| cap_pulse | output | 1 | One-cycle strap capture marker |
| test_mode | output | 1 | Latched test-mode flag |
| cpu_code | output | FS_W+2 | Processor selection: table, spread, frequency |
| cpu_spread | output | 1 | Processor and PCI spread enable |
| periph_code | output | 4 | Peripheral frequency code |
| periph_step | output | 2 | Peripheral overclock step |
| periph_spread | output | 1 | Peripheral domain spread enable |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. The capture latency checks therefore test the SYNC_STAGES+1 relation and not a fixed count. FS_W stays at 3, so every reserved and valid code in both tables can be driven, and all sixteen peripheral codes are swept. A second reset in the middle of the run makes it possible to check the test-mode latch and a reserved strap value.

// File: rtl/strap_sel_pkg.sv
package strap_sel_pkg;
  localparam int FS_W        = 3;
  localparam int CODE_W      = FS_W + 2;
  localparam int SRC_BIT     = 7;
  localparam int MSPR_BIT    = 6;
  localparam int TBL_BIT     = 4;
  localparam int SPR_BIT     = 3;
  localparam int PSPR_BIT    = 4;
  localparam int PCODE_W     = 4;
  localparam int STEP_W      = 2;
  localparam int STEP_LSB    = PCODE_W - STEP_W;

  localparam logic [FS_W-1:0] FS_RESERVED = 3'b111;
  localparam logic [FS_W-1:0] FS_BASE     = 3'b101;

  typedef struct packed {
    logic            tbl;
    logic            spr;
    logic [FS_W-1:0] fs;
  } cpu_code_t;

  function automatic cpu_code_t fold_reserved(cpu_code_t c);
    cpu_code_t r;
    r = c;
    if (!c.tbl && (c.fs == FS_RESERVED)) r.fs = FS_BASE;
    return r;
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh_q <= {STAGES{RST_VAL}};
    else if (en) sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pg_n_s,
  input  logic [FS_W-1:0] strap_fs,
  input  logic            strap_tbl,
  input  logic            strap_test,
  output logic            captured,
  output logic            cap_pulse,
  output logic [FS_W-1:0] fs_lat,
  output logic            tbl_lat,
  output logic            test_mode
);
  logic            take;
  logic            cap_q, cap_d, pulse_q, pulse_d, test_q, test_d, tbl_q, tbl_d;
  logic [FS_W-1:0] fs_q, fs_d;

  always_comb begin
    take    = !pg_n_s && !cap_q;
    cap_d   = cap_q | take;
    pulse_d = take;
    fs_d    = take ? strap_fs   : fs_q;
    tbl_d   = take ? strap_tbl  : tbl_q;
    test_d  = take ? strap_test : test_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      pulse_q <= 1'b0;
      fs_q    <= '0;
      tbl_q   <= 1'b0;
      test_q  <= 1'b0;
    end else if (en) begin
      cap_q   <= cap_d;
      pulse_q <= pulse_d;
      fs_q    <= fs_d;
      tbl_q   <= tbl_d;
      test_q  <= test_d;
    end
  end

  assign captured  = cap_q;
  assign cap_pulse = pulse_q;
  assign fs_lat    = fs_q;
  assign tbl_lat   = tbl_q;
  assign test_mode = test_q;

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
  assert_drive_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> captured);
  assert_once_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && !cap_pulse) |=> !cap_pulse);
  assert_test_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(test_mode));
endmodule

// File: rtl/freq_select.sv
module freq_select
  import strap_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              captured,
  input  logic              tbl_lat,
  input  logic [FS_W-1:0]   fs_lat,
  input  logic [7:0]        ctrl_reg,
  input  logic [PSPR_BIT:0] periph_reg,
  output logic [CODE_W-1:0] cpu_code,
  output logic              cpu_spread,
  output logic [PCODE_W-1:0] periph_code,
  output logic [STEP_W-1:0] periph_step,
  output logic              periph_spread
);
  cpu_code_t                pick, code_d, code_q;
  logic                     cspr_d, cspr_q, pspr_d, pspr_q;
  logic [PCODE_W-1:0]       pcode_d, pcode_q;
  logic                     unused_rsvd;

  assign unused_rsvd = ctrl_reg[5];

  always_comb begin
    pick.spr = ctrl_reg[SPR_BIT];
    if (ctrl_reg[SRC_BIT]) begin
      pick.tbl = ctrl_reg[TBL_BIT];
      pick.fs  = ctrl_reg[FS_W-1:0];
    end else if (captured) begin
      pick.tbl = tbl_lat;
      pick.fs  = fs_lat;
    end else begin
      pick.tbl = 1'b0;
      pick.fs  = FS_BASE;
    end
    code_d  = fold_reserved(pick);
    cspr_d  = ctrl_reg[MSPR_BIT] & ctrl_reg[SPR_BIT];
    pcode_d = periph_reg[PCODE_W-1:0];
    pspr_d  = periph_reg[PSPR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '{tbl: 1'b0, spr: 1'b0, fs: FS_BASE};
      cspr_q  <= 1'b0;
      pcode_q <= '0;
      pspr_q  <= 1'b0;
    end else if (en) begin
      code_q  <= code_d;
      cspr_q  <= cspr_d;
      pcode_q <= pcode_d;
      pspr_q  <= pspr_d;
    end
  end

  assign cpu_code      = code_q;
  assign cpu_spread    = cspr_q;
  assign periph_code   = pcode_q;
  assign periph_step   = pcode_q[PCODE_W-1:STEP_LSB];
  assign periph_spread = pspr_q;

  assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cpu_code[CODE_W-1] && (cpu_code[FS_W-1:0] == FS_RESERVED)));
  assert_spread_needs_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_spread |-> cpu_code[FS_W]);
  assert_freeze_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cpu_code));
  assert_freeze_periph_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(periph_code) && $stable(periph_spread)));
  assert_strap_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!captured && !ctrl_reg[SRC_BIT] && en) |=> (cpu_code[FS_W-1:0] == FS_BASE));
endmodule

// File: rtl/strap_freq_ctrl.sv
module strap_freq_ctrl
  import strap_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_dn,
  input  logic               pg_n,
  input  logic [FS_W-1:0]    strap_fs,
  input  logic               strap_tbl,
  input  logic               strap_test,
  input  logic [7:0]         ctrl_reg,
  input  logic [PSPR_BIT:0]  periph_reg,
  output logic               strap_drive,
  output logic               cap_pulse,
  output logic               test_mode,
  output logic [CODE_W-1:0]  cpu_code,
  output logic               cpu_spread,
  output logic [PCODE_W-1:0] periph_code,
  output logic [STEP_W-1:0]  periph_step,
  output logic               periph_spread
);
  logic            run_en, pg_n_s, captured, tbl_lat;
  logic [FS_W-1:0] fs_lat;

  assign run_en = !pwr_dn;

  pg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .en(run_en), .d(pg_n), .q(pg_n_s)
  );

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .en(run_en), .pg_n_s(pg_n_s),
    .strap_fs(strap_fs), .strap_tbl(strap_tbl), .strap_test(strap_test),
    .captured(captured), .cap_pulse(cap_pulse), .fs_lat(fs_lat),
    .tbl_lat(tbl_lat), .test_mode(test_mode)
  );

  freq_select u_sel (
    .clk(clk), .rst_n(rst_n), .en(run_en), .captured(captured),
    .tbl_lat(tbl_lat), .fs_lat(fs_lat), .ctrl_reg(ctrl_reg),
    .periph_reg(periph_reg), .cpu_code(cpu_code), .cpu_spread(cpu_spread),
    .periph_code(periph_code), .periph_step(periph_step),
    .periph_spread(periph_spread)
  );

  assign strap_drive = captured;
endmodule

// File: tb/tb_strap_freq_ctrl.sv
module tb_strap_freq_ctrl;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n, pwr_dn, pg_n, strap_tbl, strap_test;
  logic [2:0] strap_fs;
  logic [7:0] ctrl_reg;
  logic [4:0] periph_reg;
  logic       strap_drive, cap_pulse, test_mode, cpu_spread, periph_spread;
  logic [4:0] cpu_code;
  logic [3:0] periph_code;
  logic [1:0] periph_step;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  strap_freq_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .pg_n(pg_n),
    .strap_fs(strap_fs), .strap_tbl(strap_tbl), .strap_test(strap_test),
    .ctrl_reg(ctrl_reg), .periph_reg(periph_reg),
    .strap_drive(strap_drive), .cap_pulse(cap_pulse), .test_mode(test_mode),
    .cpu_code(cpu_code), .cpu_spread(cpu_spread), .periph_code(periph_code),
    .periph_step(periph_step), .periph_spread(periph_spread)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pg_n = 1'b1; pwr_dn = 1'b0;
    cyc(2);
    check("R1 drive",   strap_drive, 0);
    check("R1 pulse",   cap_pulse, 0);
    check("R1 test",    test_mode, 0);
    check("R1 code",    cpu_code, 5'b00101);
    check("R1 cspread", cpu_spread, 0);
    check("R1 step",    periph_step, 0);
    check("R1 pspread", periph_spread, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_precapture();
    ctrl_reg = 8'h08; strap_fs = 3'b010; strap_tbl = 1'b0;
    cyc(2);
    check("R7 code before capture", cpu_code, 5'b01101);
  endtask

  task automatic t_capture();
    ctrl_reg = 8'h00;
    pg_n = 1'b0;
    for (int k = 1; k < LAT; k++) begin
      cyc(1);
      check("R2 no early pulse", cap_pulse, 0);
    end
    cyc(1);
    check("R2 pulse", cap_pulse, 1);
    check("R2 drive", strap_drive, 1);
    cyc(1);
    check("R2 pulse width", cap_pulse, 0);
    check("R4 strap source", cpu_code, 5'b00010);
  endtask

  task automatic t_once();
    int seen = 0;
    strap_fs = 3'b100; strap_tbl = 1'b1; strap_test = 1'b1;
    pg_n = 1'b1;
    for (int i = 0; i < 4; i++) begin cyc(1); seen += cap_pulse; end
    pg_n = 1'b0;
    for (int i = 0; i < 8; i++) begin cyc(1); seen += cap_pulse; end
    check("R3 no second pulse", seen, 0);
    check("R3 code kept", cpu_code, 5'b00010);
    check("R3 test kept", test_mode, 0);
    check("R2 drive held", strap_drive, 1);
  endtask

  task automatic t_reg_source();
    ctrl_reg = 8'b1001_0110;
    #1;
    check("R11 not before edge", cpu_code, 5'b00010);
    cyc(1);
    check("R4 register source", cpu_code, 5'b10110);
  endtask

  task automatic t_spread();
    ctrl_reg = 8'b1100_1001; cyc(1);
    check("R5 code", cpu_code, 5'b01001);
    check("R5 spread on", cpu_spread, 1);
    ctrl_reg = 8'b1000_1001; cyc(1);
    check("R5 master off", cpu_spread, 0);
    ctrl_reg = 8'b1100_0001; cyc(1);
    check("R5 bit3 off", cpu_spread, 0);
    ctrl_reg = 8'b0100_1000; cyc(1);
    check("R5 pin source bit3", cpu_code, 5'b01010);
    check("R5 pin source spread", cpu_spread, 1);
  endtask

  task automatic t_reserved();
    ctrl_reg = 8'b1000_1111; cyc(1);
    check("R6 reserved folded", cpu_code, 5'b01101);
    ctrl_reg = 8'b1001_0111; cyc(1);
    check("R6 other table valid", cpu_code, 5'b10111);
  endtask

  task automatic t_periph();
    for (int i = 0; i < 16; i++) begin
      periph_reg = 5'(i) | ((i % 2 == 1) ? 5'h10 : 5'h00);
      cyc(1);
      check("R8 code",   periph_code, i);
      check("R8 step",   periph_step, i / 4);
      check("R8 spread", periph_spread, i % 2);
    end
  endtask

  task automatic t_pwr_down();
    logic [4:0] held;
    logic [3:0] pheld;
    held = cpu_code; pheld = periph_code;
    pwr_dn = 1'b1;
    ctrl_reg = 8'b1000_0001; periph_reg = 5'h02;
    cyc(3);
    check("R10 code frozen",   cpu_code, held);
    check("R10 periph frozen", periph_code, pheld);
    pwr_dn = 1'b0;
    cyc(1);
    check("R10 resumes", cpu_code, 5'b00001);
    check("R10 periph resumes", periph_code, 4'h2);
  endtask

  task automatic t_test_mode();
    do_reset();
    ctrl_reg = 8'h00; strap_fs = 3'b111; strap_tbl = 1'b0; strap_test = 1'b1;
    pwr_dn = 1'b1; pg_n = 1'b0;
    cyc(LAT + 3);
    check("R10 capture postponed", strap_drive, 0);
    pwr_dn = 1'b0;
    cyc(LAT);
    check("R10 capture after release", cap_pulse, 1);
    check("R9 test latched", test_mode, 1);
    cyc(1);
    check("R6 reserved strap folded", cpu_code, 5'b00101);
    strap_test = 1'b0; pg_n = 1'b1; cyc(5); pg_n = 1'b0; cyc(6);
    check("R9 test held", test_mode, 1);
    do_reset();
    check("R9 cleared by reset", test_mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0; pg_n = 1'b1;
    strap_fs = 3'b000; strap_tbl = 1'b0; strap_test = 1'b0;
    ctrl_reg = 8'h00; periph_reg = 5'h00;
    do_reset();
    t_precapture();
    t_capture();
    t_once();
    t_reg_source();
    t_spread();
    t_reserved();
    t_periph();
    t_pwr_down();
    t_test_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule